// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a fully associative translation buffer whose contents are owned entirely by software. Each of its entries pairs a tag word with a data word. The tag word carries an effective page number, a 3-bit size code and a valid flag. The data word carries a real page number, execute and write permission bits, a 4-bit zone selector and four cache/ordering attribute bits. Software fills entries one half at a time through an indexed write port and inspects them through an indexed read port. A half-select bit of 0 addresses the tag word and 1 addresses the data word.

Two lookup ports compare an address against every entry in the same cycle. The search port returns whether any entry matched, the lowest matching index, and a flag when more than one entry matched. The translate port uses the lowest-numbered matching entry to build a physical address. It also returns that entry's permissions and attributes, and raises a protection fault when the access type is not permitted. Each entry has its own page size, so every entry masks a different number of page-number bits. Both lookup ports are combinational from the stored state. A write takes effect at the next rising clock edge.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid and both words of every entry read as zero. The search and translate ports report no hit, and all translate outputs are zero.
- R2: A write with half-select 0 stores the word into the tag of the indexed entry, and half-select 1 stores it into the data word. The indexed read port returns the selected stored word unchanged, combinationally, from the cycle after the write.
- R3: The tag word holds the page number in bits [31:10], the size code in bits [9:7] and the valid flag in bit 6. For size code n (0..7, meaning 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M), the comparison leaves out the low 2n bits of the page number.
- R4: The search port asserts its hit output when at least one valid entry matches the address. It returns the lowest index among the matching entries.
- R5: The search multi-hit output is high exactly when two or more valid entries match the search address.
- R6: On a translate hit, physical address bits [9:0] equal the address bits [9:0]. Of the page-number bits [31:10], the low 2n bits come from the address and the rest come from the real page number of the lowest matching entry. On a miss the physical address is zero.
- R7: The data word holds the real page number in [31:10], execute-enable in bit 9, write-enable in bit 8, the zone in [7:4] and the attributes in [3:0]. On a translate hit the outputs present these fields of the lowest matching entry, and on a miss they are zero.
- R8: The protection-fault output is high exactly when the translate lookup hits and either a write is requested to an entry with write-enable clear, or a fetch is requested from an entry with execute-enable clear.
- R9: An entry whose valid flag is clear never matches on either port, whatever its page number.
- R10: A write changes only the addressed half of the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_half_i | input | 1 | Write half: 0 tag, 1 data |
| wr_idx_i | input | 6 | Entry to write |
| wr_data_i | input | 32 | Word to write |
| rd_idx_i | input | 6 | Entry to read |
| rd_half_i | input | 1 | Read half: 0 tag, 1 data |
| rd_data_o | output | 32 | Selected stored word |
| srch_ea_i | input | 32 | Search address |
| srch_hit_o | output | 1 | Search found a match |
| srch_idx_o | output | 6 | Lowest matching index |
| srch_multi_o | output | 1 | More than one entry matched |
| xl_ea_i | input | 32 | Translate address |
| xl_write_i | input | 1 | Translate access is a write |
| xl_fetch_i | input | 1 | Translate access is an instruction fetch |
| xl_hit_o | output | 1 | Translate found a match |
| xl_pa_o | output | 32 | Physical address |
| xl_exec_o | output | 1 | Execute-enable of the matched entry |
| xl_wren_o | output | 1 | Write-enable of the matched entry |
| xl_zone_o | output | 4 | Zone of the matched entry |
| xl_wimg_o | output | 4 | Attribute bits of the matched entry |
| xl_fault_o | output | 1 | Protection fault |

## Verification
The assertions check several properties on every cycle. A reported search index points at an entry that really matches, with no lower match. A multi-hit or a fault never appears without a hit. The page offset always passes through on a translate hit. An invalid entry raises no match. A write lands only in its own half. The exact physical address merge for each size code, the choice among overlapping entries, and the permission values can only be shown by the bench's scenarios. Those scenarios compare each output against an independent model every clock.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;
  localparam int WORD_W = 32;
  localparam int PG_LSB = 10;
  localparam int EPN_W  = WORD_W - PG_LSB;
  localparam int SZ_W   = 3;
  localparam logic HALF_TAG = 1'b0;

  typedef struct packed {
    logic [EPN_W-1:0] epn;
    logic [SZ_W-1:0]  size;
    logic             valid;
    logic [5:0]       rsvd;
  } tag_t;

  typedef struct packed {
    logic [EPN_W-1:0] rpn;
    logic             ex;
    logic             wr;
    logic [3:0]       zone;
    logic [3:0]       wimg;
  } dat_t;

  // ones where the page number takes part in the compare
  function automatic logic [EPN_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
    return {EPN_W{1'b1}} << {sz, 1'b0};
  endfunction
endpackage

// File: rtl/vpage_tlb_entry.sv
module vpage_tlb_entry
  import vpage_tlb_pkg::*;
#(
  parameter int N_LOOK = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_tag_i,
  input  logic                          wr_dat_i,
  input  logic [WORD_W-1:0]             wdata_i,
  input  logic [N_LOOK-1:0][EPN_W-1:0]  look_epn_i,
  output tag_t                          tag_o,
  output dat_t                          dat_o,
  output logic [N_LOOK-1:0]             hit_o
);
  tag_t tag_q;
  dat_t dat_q;
  logic [EPN_W-1:0] cmp_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_tag_i) tag_q <= tag_t'(wdata_i);
      if (wr_dat_i) dat_q <= dat_t'(wdata_i);
    end
  end

  assign cmp_mask = size_mask(tag_q.size);

  for (genvar p = 0; p < N_LOOK; p++) begin : g_look
    assign hit_o[p] = tag_q.valid &&
                      (((tag_q.epn ^ look_epn_i[p]) & cmp_mask) == '0);
  end

  assign tag_o = tag_q;
  assign dat_o = dat_q;

  a_r10_tag_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tag_i |=> tag_q == tag_t'($past(wdata_i)));
  a_r10_half_isolate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat_i && !wr_tag_i) |=> $stable(tag_q));
  a_r9_invalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_q.valid |-> hit_o == '0);
endmodule

// File: rtl/vpage_tlb_prio.sv
module vpage_tlb_prio #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             multi_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    multi_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        if (found_o) multi_o = 1'b1;
        else begin
          found_o = 1'b1;
          idx_o   = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpage_tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_half_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              rd_half_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [WORD_W-1:0] srch_ea_i,
  output logic              srch_hit_o,
  output logic [IDX_W-1:0]  srch_idx_o,
  output logic              srch_multi_o,
  input  logic [WORD_W-1:0] xl_ea_i,
  input  logic              xl_write_i,
  input  logic              xl_fetch_i,
  output logic              xl_hit_o,
  output logic [WORD_W-1:0] xl_pa_o,
  output logic              xl_exec_o,
  output logic              xl_wren_o,
  output logic [3:0]        xl_zone_o,
  output logic [3:0]        xl_wimg_o,
  output logic              xl_fault_o
);
  localparam int N_LOOK = 2;
  localparam int P_SRCH = 0;
  localparam int P_XL   = 1;

  tag_t             tags [N_ENT];
  dat_t             dats [N_ENT];
  logic [N_ENT-1:0] s_vec, x_vec;
  logic [N_LOOK-1:0][EPN_W-1:0] look_epn;

  assign look_epn[P_SRCH] = srch_ea_i[WORD_W-1:PG_LSB];
  assign look_epn[P_XL]   = xl_ea_i[WORD_W-1:PG_LSB];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [N_LOOK-1:0] hv;
    logic wsel;
    assign wsel = wr_en_i && (wr_idx_i == IDX_W'(e));
    vpage_tlb_entry #(.N_LOOK(N_LOOK)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_tag_i  (wsel && (wr_half_i == HALF_TAG)),
      .wr_dat_i  (wsel && (wr_half_i != HALF_TAG)),
      .wdata_i   (wr_data_i),
      .look_epn_i(look_epn),
      .tag_o     (tags[e]),
      .dat_o     (dats[e]),
      .hit_o     (hv)
    );
    assign s_vec[e] = hv[P_SRCH];
    assign x_vec[e] = hv[P_XL];
  end

  assign rd_data_o = (rd_half_i == HALF_TAG) ? WORD_W'(tags[rd_idx_i])
                                             : WORD_W'(dats[rd_idx_i]);

  vpage_tlb_prio #(.N(N_ENT)) u_srch_prio (
    .vec_i  (s_vec),
    .found_o(srch_hit_o),
    .idx_o  (srch_idx_o),
    .multi_o(srch_multi_o)
  );

  logic             x_found, x_multi;
  logic [IDX_W-1:0] x_idx;
  vpage_tlb_prio #(.N(N_ENT)) u_xl_prio (
    .vec_i  (x_vec),
    .found_o(x_found),
    .idx_o  (x_idx),
    .multi_o(x_multi)
  );

  dat_t             x_dat;
  logic [EPN_W-1:0] x_mask, x_epn;
  logic             x_unused;

  assign x_unused = x_multi;
  assign x_dat    = dats[x_idx];
  assign x_mask   = size_mask(tags[x_idx].size);
  // upper bits from the entry, low 2n page bits from the address
  assign x_epn    = (x_dat.rpn & x_mask) | (xl_ea_i[WORD_W-1:PG_LSB] & ~x_mask);

  always_comb begin
    xl_hit_o   = x_found;
    xl_pa_o    = '0;
    xl_exec_o  = 1'b0;
    xl_wren_o  = 1'b0;
    xl_zone_o  = '0;
    xl_wimg_o  = '0;
    xl_fault_o = 1'b0;
    if (x_found) begin
      xl_pa_o    = {x_epn, xl_ea_i[PG_LSB-1:0]};
      xl_exec_o  = x_dat.ex;
      xl_wren_o  = x_dat.wr;
      xl_zone_o  = x_dat.zone;
      xl_wimg_o  = x_dat.wimg;
      xl_fault_o = (xl_write_i && !x_dat.wr) || (xl_fetch_i && !x_dat.ex);
    end
  end

  a_r4_idx_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_hit_o |-> s_vec[srch_idx_o]);
  a_r4_none_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_hit_o |-> (s_vec & ((N_ENT'(1) << srch_idx_o) - N_ENT'(1))) == '0);
  a_r5_multi_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_multi_o |-> srch_hit_o);
  a_r6_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_hit_o |-> xl_pa_o[PG_LSB-1:0] == xl_ea_i[PG_LSB-1:0]);
  a_r7_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xl_hit_o |-> (xl_pa_o == '0 && xl_zone_o == '0 && xl_wimg_o == '0));
  a_r8_fault_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_fault_o |-> xl_hit_o);
endmodule

// File: tb/vpage_tlb_test.sv
module vpage_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_half = 1'b0;
  logic [5:0]  wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, srch_ea = '0, xl_ea = '0;
  logic        rd_half = 1'b0, xl_write = 1'b0, xl_fetch = 1'b0;
  logic [31:0] rd_data, xl_pa;
  logic        srch_hit, srch_multi, xl_hit, xl_exec, xl_wren, xl_fault;
  logic [5:0]  srch_idx;
  logic [3:0]  xl_zone, xl_wimg;

  int n_chk = 0, n_fail = 0;
  bit run = 1'b0, done = 1'b0;

  logic [31:0] m_tag [NE];
  logic [31:0] m_dat [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpage_tlb uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_half_i(wr_half), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_half_i(rd_half), .rd_data_o(rd_data),
    .srch_ea_i(srch_ea), .srch_hit_o(srch_hit), .srch_idx_o(srch_idx),
    .srch_multi_o(srch_multi),
    .xl_ea_i(xl_ea), .xl_write_i(xl_write), .xl_fetch_i(xl_fetch),
    .xl_hit_o(xl_hit), .xl_pa_o(xl_pa), .xl_exec_o(xl_exec), .xl_wren_o(xl_wren),
    .xl_zone_o(xl_zone), .xl_wimg_o(xl_wimg), .xl_fault_o(xl_fault)
  );

  // reference storage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin m_tag[i] <= '0; m_dat[i] <= '0; end
    end else if (wr_en) begin
      if (wr_half) m_dat[wr_idx] <= wr_data;
      else         m_tag[wr_idx] <= wr_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit m_match(input int i, input logic [31:0] ea);
    logic [21:0] msk;
    msk = 22'h3fffff << (2 * int'(m_tag[i][9:7]));
    return m_tag[i][6] && (((m_tag[i][31:10] ^ ea[31:10]) & msk) == 22'h0);
  endfunction

  task automatic compare_all();
    bit f; int idx; bit mul;
    logic [31:0] pa; logic [21:0] msk; logic [31:0] d;
    f = 0; idx = 0; mul = 0;
    for (int i = 0; i < NE; i++)
      if (m_match(i, srch_ea)) begin if (f) mul = 1; else begin f = 1; idx = i; end end
    chk("R2 read", rd_data, rd_half ? m_dat[rd_idx] : m_tag[rd_idx]);
    chk("R4 hit", 32'(srch_hit), 32'(f));
    if (f) chk("R4 index", 32'(srch_idx), 32'(idx));
    chk("R5 multi", 32'(srch_multi), 32'(mul));
    f = 0; idx = 0;
    for (int i = 0; i < NE; i++)
      if (!f && m_match(i, xl_ea)) begin f = 1; idx = i; end
    chk("R6 xl hit", 32'(xl_hit), 32'(f));
    if (f) begin
      d = m_dat[idx];
      msk = 22'h3fffff << (2 * int'(m_tag[idx][9:7]));
      pa = {(d[31:10] & msk) | (xl_ea[31:10] & ~msk), xl_ea[9:0]};
      chk("R6 pa", xl_pa, pa);
      chk("R7 attrs", {22'h0, xl_exec, xl_wren, xl_zone, xl_wimg}, {22'h0, d[9:0]});
      chk("R8 fault", 32'(xl_fault), 32'((xl_write && !d[8]) || (xl_fetch && !d[9])));
    end else begin
      chk("R6 miss pa", xl_pa, 32'h0);
      chk("R7 miss attrs", {22'h0, xl_exec, xl_wren, xl_zone, xl_wimg}, 32'h0);
      chk("R8 miss fault", 32'(xl_fault), 32'h0);
    end
  endtask

  always @(negedge clk) if (run && rst_n) compare_all();

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input int idx, input bit half, input logic [31:0] d);
    wr_en = 1; wr_idx = 6'(idx); wr_half = half; wr_data = d;
    step();
    wr_en = 0;
  endtask

  function automatic logic [31:0] mk_tag(input logic [21:0] epn, input logic [2:0] sz, input bit v);
    return {epn, sz, v, 6'h0};
  endfunction
  function automatic logic [31:0] mk_dat(input logic [21:0] rpn, input bit ex, input bit w,
                                         input logic [3:0] z, input logic [3:0] a);
    return {rpn, ex, w, z, a};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1; run = 1;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_idx = 6'(i * 17); rd_half = i[0];
      srch_ea = 32'h0; xl_ea = 32'h0;
      #2 chk("R1 reset read", rd_data, 32'h0);
      chk("R1 reset miss", {30'h0, srch_hit, xl_hit}, 32'h0);
      step();
    end
    // 1K page, exec only
    wr(5, 0, mk_tag(22'h00123, 3'd0, 1));
    wr(5, 1, mk_dat(22'h3abcd, 1, 0, 4'h3, 4'ha));
    srch_ea = {22'h00123, 10'h155}; xl_ea = {22'h00123, 10'h2f0};
    xl_write = 1; xl_fetch = 0; #2;
    chk("R4 found idx5", {25'h0, srch_hit, srch_idx}, {25'h0, 1'b1, 6'd5});
    chk("R8 write fault", 32'(xl_fault), 32'h1);
    chk("R6 1K pa", xl_pa, {22'h3abcd, 10'h2f0});
    step();
    xl_write = 0; xl_fetch = 1; #2 chk("R8 fetch ok", 32'(xl_fault), 32'h0);
    step();
    // 16M page: low 14 page bits come from the address
    wr(9, 0, mk_tag(22'h2a1234, 3'd7, 1));
    wr(9, 1, mk_dat(22'h155555, 0, 1, 4'h7, 4'h5));
    xl_ea = {22'h2a3fff, 10'h001}; xl_fetch = 1; #2;
    chk("R3 16M match", 32'(xl_hit), 32'h1);
    chk("R6 16M pa", xl_pa, {8'h55, 14'h3fff, 10'h001});
    chk("R8 fetch fault", 32'(xl_fault), 32'h1);
    step();
    xl_ea = {22'h2b0000, 10'h0}; #2 chk("R3 16M out of range", 32'(xl_hit), 32'h0);
    step();
    // 64K page, overlap with entry 2 for multi-hit
    wr(10, 0, mk_tag(22'h000400, 3'd3, 1));
    wr(2, 0, mk_tag(22'h000410, 3'd1, 1));
    srch_ea = {22'h000413, 10'h0}; #2;
    chk("R5 multi hit", {24'h0, srch_multi, srch_hit, srch_idx}, {24'h0, 2'b11, 6'd2});
    chk("R3 64K mask", {31'h0, srch_hit}, 32'h1);
    step();
    // R9: invalidate entry 2
    wr(2, 0, mk_tag(22'h000410, 3'd1, 0)); #2;
    chk("R9 invalid skipped", {24'h0, srch_multi, srch_hit, srch_idx}, {24'h0, 2'b01, 6'd10});
    step();
    // R10: data write leaves tag alone
    wr(10, 1, mk_dat(22'h0, 1, 1, 4'hf, 4'hf));
    rd_idx = 10; rd_half = 0; #2;
    chk("R10 tag intact", rd_data, mk_tag(22'h000400, 3'd3, 1));
    step();
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 2) == 0) begin
        wr_en = 1; wr_idx = 6'($urandom); wr_half = 1'($urandom);
        wr_data = {8'h0, 2'($urandom), 10'h0, 2'($urandom), 10'($urandom)};
      end else wr_en = 0;
      srch_ea = {8'h0, 2'($urandom), 10'($urandom_range(0, 3) << 8), 2'($urandom), 10'($urandom)};
      xl_ea   = {8'h0, 2'($urandom), 10'($urandom_range(0, 3) << 8), 2'($urandom), 10'($urandom)};
      xl_write = 1'($urandom); xl_fetch = 1'($urandom);
      rd_idx = 6'($urandom); rd_half = 1'($urandom);
      step();
    end
    wr_en = 0;
    step();
    run = 0;
    finish_run();
  end
endmodule